// File: doc/BRIEF.md
# Power Mode and Clock Sequencer

This controller steps a small system-on-chip between three power modes: run, direct-run and halt. In run, the CPU clock is taken from the PLL and both bus clocks are divided down from the PLL rate. In direct-run, the CPU and both bus clocks run from the main-oscillator clock, which is roughly 13 MHz. In halt, that oscillator clock is gated off, the CPU and bus clocks stop, and only the 32 kHz always-on logic keeps running. The PLL may be switched on or off only in direct-run. Every path between run and halt passes through direct-run.

A suspend request starts a fixed sequence. The DRAM is first put into self-refresh and its acknowledge is awaited. Then the clock source switches to the oscillator, the PLL enable is saved and then cleared, and the block halts. Only a wake event whose enable bit is set can leave halt, and it always exits into direct-run. The saved PLL state is then restored, and the block waits for PLL lock before it switches back to run. After that the self-refresh request is dropped and the block waits for the acknowledge to fall. A configuration bit can stop the SDRAM clock for as long as self-refresh is acknowledged. After reset the block is in direct-run with the PLL off. A run request in that state starts the PLL and moves to run once the PLL locks.

Top module: `pwr_mode_seq`

## Requirements
- R1: On reset, mode reads direct-run (mode encoding: run = 2'b00, direct-run = 2'b01, halt = 2'b10), clk_sel = 0, pll_en = 0, sysclk_en = 1, sref_req = 0, pll_saved = 0. The value 2'b11 never appears on mode.
- R2: A run_req that is high in idle direct-run sets pll_en at the next clock edge. At the edge after pll_lock is seen high, mode becomes run and clk_sel becomes 1. A run_req in any other state is ignored.
- R3: clk_sel is 1 (PLL source) whenever mode is run, and then pll_en is also 1. clk_sel is 0 (oscillator source) in direct-run and in halt.
- R4: suspend_req is accepted only when the block is settled in run mode. In any other state it leaves every output unchanged.
- R5: The suspend order is fixed. sref_req rises first. At the edge after sref_ack is seen high, mode becomes direct-run, clk_sel becomes 0 and pll_saved captures pll_en. On the next edge pll_en falls. On the edge after that, mode becomes halt.
- R6: In halt, sysclk_en is 0. Halt is left only when some bit is high in both wake_evt and wake_en. At the following edge, mode is direct-run, sysclk_en is 1 and pll_en equals pll_saved.
- R7: Wake events seen while the block is not in halt have no effect.
- R8: The resume order is fixed. After the wake, the block waits in direct-run for pll_lock. It then switches to run, and only after that does sref_req fall. The block is back in settled run once sref_ack is low.
- R9: sdram_clk_en is 0 exactly when sdclk_autostop is 1 and both sref_req and sref_ack are high. Otherwise it is 1.
- R10: pll_en changes value only while mode is direct-run.
- R11: mode never goes from run straight to halt, and never from halt straight to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Start the PLL and move to run from idle direct-run |
| suspend_req | input | 1 | Begin the suspend sequence (run mode only) |
| pll_lock | input | 1 | PLL has locked |
| sref_ack | input | 1 | DRAM self-refresh acknowledge |
| wake_evt | input | NUM_WAKE | Wake event lines |
| wake_en | input | NUM_WAKE | Per-line wake enable mask |
| sdclk_autostop | input | 1 | Stop the SDRAM clock while self-refresh is acknowledged |
| clk_sel | output | 1 | Clock source: 1 = PLL, 0 = oscillator |
| pll_en | output | 1 | PLL enable |
| sysclk_en | output | 1 | Oscillator clock gate (0 in halt) |
| sref_req | output | 1 | DRAM self-refresh request |
| sdram_clk_en | output | 1 | SDRAM clock enable |
| mode | output | 2 | Current power mode |
| pll_saved | output | 1 | PLL enable saved across halt |

## Verification
The assertions assume that the outside world follows its side of the two handshakes. sref_ack only follows sref_req, with a delay. pll_lock is raised only after pll_en has been held high for a while, and it drops as soon as pll_en falls. All inputs are also assumed to be synchronous to clk. The bench keeps within these limits by modelling both handshakes itself. The DRAM acknowledge is a register that copies sref_req one cycle late, and the PLL lock comes from a counter that clears whenever pll_en is low. Every input is changed a few nanoseconds after the rising edge, so that each one is stable when it is sampled.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_DIRECT = 2'b01,
        MODE_HALT   = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        SQ_DIRECT,
        SQ_LOCK,
        SQ_RELEASE,
        SQ_RUN,
        SQ_SR_ENTER,
        SQ_PLL_OFF,
        SQ_HALT_GO,
        SQ_HALT
    } seq_e;

    typedef struct packed {
        seq_e  st;
        mode_e mode;
        logic  clk_sel;
        logic  pll_en;
        logic  sysclk_en;
        logic  sref_req;
        logic  saved;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st:        SQ_DIRECT,
        mode:      MODE_DIRECT,
        clk_sel:   1'b0,
        pll_en:    1'b0,
        sysclk_en: 1'b1,
        sref_req:  1'b0,
        saved:     1'b0
    };

endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
    parameter int NUM_WAKE = 8
) (
    input  logic [NUM_WAKE-1:0] evt,
    input  logic [NUM_WAKE-1:0] en,
    output logic                hit
);
    logic [NUM_WAKE-1:0] qual;

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_line
        assign qual[i] = evt[i] & en[i];
    end

    assign hit = |qual;
endmodule

// File: rtl/pms_sdclk_ctl.sv
module pms_sdclk_ctl (
    input  logic autostop,
    input  logic sref_req,
    input  logic sref_ack,
    output logic sdram_clk_en
);
    // Clock stops only once self-refresh is both requested and confirmed.
    assign sdram_clk_en = ~(autostop & sref_req & sref_ack);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int NUM_WAKE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_req,
    input  logic                suspend_req,
    input  logic                pll_lock,
    input  logic                sref_ack,
    input  logic [NUM_WAKE-1:0] wake_evt,
    input  logic [NUM_WAKE-1:0] wake_en,
    input  logic                sdclk_autostop,
    output logic                clk_sel,
    output logic                pll_en,
    output logic                sysclk_en,
    output logic                sref_req,
    output logic                sdram_clk_en,
    output logic [1:0]          mode,
    output logic                pll_saved
);
    ctl_t r_d, r_q;
    logic wake_hit;

    pms_wake_qual #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .evt (wake_evt),
        .en  (wake_en),
        .hit (wake_hit)
    );

    pms_sdclk_ctl u_sdclk (
        .autostop     (sdclk_autostop),
        .sref_req     (r_q.sref_req),
        .sref_ack     (sref_ack),
        .sdram_clk_en (sdram_clk_en)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_DIRECT: begin
                if (run_req) begin
                    r_d.pll_en = 1'b1;
                    r_d.st     = SQ_LOCK;
                end
            end
            SQ_LOCK: begin
                if (pll_lock) begin
                    r_d.mode    = MODE_RUN;
                    r_d.clk_sel = 1'b1;
                    r_d.st      = r_q.sref_req ? SQ_RELEASE : SQ_RUN;
                end
            end
            SQ_RELEASE: begin
                r_d.sref_req = 1'b0;
                if (!sref_ack) r_d.st = SQ_RUN;
            end
            SQ_RUN: begin
                if (suspend_req) begin
                    r_d.sref_req = 1'b1;
                    r_d.st       = SQ_SR_ENTER;
                end
            end
            SQ_SR_ENTER: begin
                if (sref_ack) begin
                    r_d.mode    = MODE_DIRECT;
                    r_d.clk_sel = 1'b0;
                    r_d.saved   = r_q.pll_en;
                    r_d.st      = SQ_PLL_OFF;
                end
            end
            SQ_PLL_OFF: begin
                r_d.pll_en = 1'b0;
                r_d.st     = SQ_HALT_GO;
            end
            SQ_HALT_GO: begin
                r_d.mode      = MODE_HALT;
                r_d.sysclk_en = 1'b0;
                r_d.st        = SQ_HALT;
            end
            SQ_HALT: begin
                if (wake_hit) begin
                    r_d.mode      = MODE_DIRECT;
                    r_d.sysclk_en = 1'b1;
                    r_d.pll_en    = r_q.saved;
                    r_d.st        = r_q.saved ? SQ_LOCK : SQ_DIRECT;
                end
            end
            default: r_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RESET;
        else        r_q <= r_d;
    end

    assign clk_sel   = r_q.clk_sel;
    assign pll_en    = r_q.pll_en;
    assign sysclk_en = r_q.sysclk_en;
    assign sref_req  = r_q.sref_req;
    assign mode      = r_q.mode;
    assign pll_saved = r_q.saved;
endmodule

// File: rtl/pms_checker.sv
module pms_checker
    import pms_pkg::*;
#(
    parameter int NUM_WAKE = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_WAKE-1:0] wake_evt,
    input logic [NUM_WAKE-1:0] wake_en,
    input logic                clk_sel,
    input logic                pll_en,
    input logic                sysclk_en,
    input logic                sref_req,
    input logic [1:0]          mode
);
    logic woke;
    assign woke = |(wake_evt & wake_en);

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    assert_run_on_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |-> (clk_sel && pll_en));

    assert_osc_outside_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN) |-> !clk_sel);

    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT) |-> (!sysclk_en && sref_req && !pll_en));

    assert_halt_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !woke) |=> (mode == MODE_HALT));

    assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && woke) |=> (mode == MODE_DIRECT && sysclk_en));

    assert_pll_moves_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_en) |-> (mode == MODE_DIRECT));

    assert_no_run_to_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |=> (mode != MODE_HALT));

    assert_no_halt_to_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT) |=> (mode != MODE_RUN));
endmodule

bind pwr_mode_seq pms_checker #(.NUM_WAKE(NUM_WAKE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_evt  (wake_evt),
    .wake_en   (wake_en),
    .clk_sel   (clk_sel),
    .pll_en    (pll_en),
    .sysclk_en (sysclk_en),
    .sref_req  (sref_req),
    .mode      (mode)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, suspend_req = 1'b0, sdclk_autostop = 1'b0;
    logic pll_lock, sref_ack = 1'b0;
    logic [NW-1:0] wake_evt = '0, wake_en = '0;
    logic clk_sel, pll_en, sysclk_en, sref_req, sdram_clk_en, pll_saved;
    logic [1:0] mode;

    int checks = 0, fails = 0;
    bit done = 0, started = 0;

    always #10 clk = ~clk;

    pwr_mode_seq #(.NUM_WAKE(NW)) uut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .suspend_req(suspend_req),
        .pll_lock(pll_lock), .sref_ack(sref_ack), .wake_evt(wake_evt),
        .wake_en(wake_en), .sdclk_autostop(sdclk_autostop), .clk_sel(clk_sel),
        .pll_en(pll_en), .sysclk_en(sysclk_en), .sref_req(sref_req),
        .sdram_clk_en(sdram_clk_en), .mode(mode), .pll_saved(pll_saved)
    );

    // Environment handshakes: DRAM ack lags the request; PLL locks after 3 cycles on.
    int lock_cnt = 0;
    always @(posedge clk) begin
        sref_ack <= sref_req;
        if (!pll_en) lock_cnt <= 0;
        else if (lock_cnt < 3) lock_cnt <= lock_cnt + 1;
    end
    assign pll_lock = (lock_cnt == 3);

    // Behavioural reference: phase counter plus expected output values.
    localparam int P_IDLE = 0, P_WAITLOCK = 1, P_UNREFRESH = 2, P_RUN = 3,
                   P_REFRESH = 4, P_STOPPLL = 5, P_GOHALT = 6, P_HALT = 7;
    int ph = P_IDLE;
    logic [1:0] e_mode = 2'b01;
    bit e_sel = 0, e_pll = 0, e_sys = 1, e_sref = 0, e_saved = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = P_IDLE; e_mode = 2'b01; e_sel = 0; e_pll = 0;
            e_sys = 1; e_sref = 0; e_saved = 0;
        end else begin
            case (ph)
                P_IDLE:      if (run_req) begin e_pll = 1; ph = P_WAITLOCK; end
                P_WAITLOCK:  if (pll_lock) begin
                                 e_mode = 2'b00; e_sel = 1;
                                 ph = e_sref ? P_UNREFRESH : P_RUN;
                             end
                P_UNREFRESH: begin e_sref = 0; if (!sref_ack) ph = P_RUN; end
                P_RUN:       if (suspend_req) begin e_sref = 1; ph = P_REFRESH; end
                P_REFRESH:   if (sref_ack) begin
                                 e_mode = 2'b01; e_sel = 0; e_saved = e_pll; ph = P_STOPPLL;
                             end
                P_STOPPLL:   begin e_pll = 0; ph = P_GOHALT; end
                P_GOHALT:    begin e_mode = 2'b10; e_sys = 0; ph = P_HALT; end
                default:     if ((wake_evt & wake_en) != '0) begin
                                 e_mode = 2'b01; e_sys = 1; e_pll = e_saved;
                                 ph = e_saved ? P_WAITLOCK : P_IDLE;
                             end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            chk(mode == e_mode, "R11 mode", mode, e_mode);
            chk(clk_sel == e_sel, "R3 clk_sel", clk_sel, e_sel);
            chk(pll_en == e_pll, "R10 pll_en", pll_en, e_pll);
            chk(sysclk_en == e_sys, "R6 sysclk_en", sysclk_en, e_sys);
            chk(sref_req == e_sref, "R5 sref_req", sref_req, e_sref);
            chk(pll_saved == e_saved, "R5 pll_saved", pll_saved, e_saved);
            chk(sdram_clk_en == !(sdclk_autostop && e_sref && sref_ack),
                "R9 sdram_clk_en", sdram_clk_en, !(sdclk_autostop && e_sref && sref_ack));
        end
    end

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic wait_mode(input logic [1:0] m);
        for (int i = 0; i < 40 && mode != m; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        started = 1;
        @(negedge clk);
        chk(mode == 2'b01 && !pll_en && !clk_sel && sysclk_en && !sref_req,
            "R1 reset state", mode, 1);

        // R7: wake events while in direct-run
        tick(); wake_evt = '1; wake_en = '1;
        tick(); tick(); wake_evt = '0; wake_en = '0;
        @(negedge clk);
        chk(mode == 2'b01 && !pll_en, "R7 wake outside halt", mode, 1);

        // R4: suspend outside run
        suspend_req = 1'b1; tick(); tick(); suspend_req = 1'b0;
        @(negedge clk);
        chk(!sref_req, "R4 suspend in direct-run", sref_req, 0);

        // R2: start the PLL and enter run
        tick(); run_req = 1'b1; tick(); run_req = 1'b0;
        @(negedge clk);
        chk(pll_en, "R2 pll_en after run_req", pll_en, 1);
        wait_mode(2'b00);
        chk(mode == 2'b00 && clk_sel, "R2 run after lock", mode, 0);

        // R7: wake in run; R2: run_req in run
        tick(); wake_evt = '1; wake_en = '1; run_req = 1'b1;
        tick(); tick(); wake_evt = '0; wake_en = '0; run_req = 1'b0;
        @(negedge clk);
        chk(mode == 2'b00 && !sref_req, "R7 wake in run", mode, 0);

        // R5/R9: suspend with SDRAM clock autostop
        sdclk_autostop = 1'b1; wake_en = 8'h04;
        tick(); suspend_req = 1'b1; tick(); suspend_req = 1'b0;
        wait_mode(2'b10);
        chk(mode == 2'b10, "R5 halt reached", mode, 2);
        chk(!sysclk_en && pll_saved, "R6 halt gating", sysclk_en, 0);
        chk(!sdram_clk_en, "R9 autostop on", sdram_clk_en, 0);

        // R6: masked wake ignored, then enabled wake
        tick(); wake_evt = 8'h01;
        repeat (4) tick();
        wake_evt = 8'h00;
        @(negedge clk);
        chk(mode == 2'b10, "R6 masked wake", mode, 2);
        tick(); wake_evt = 8'h04; tick(); wake_evt = 8'h00;
        @(negedge clk);
        chk(mode == 2'b01 && pll_en && sysclk_en, "R6 wake to direct-run", mode, 1);

        // R8: resume to run, then self-refresh released
        wait_mode(2'b00);
        chk(sref_req, "R8 run before release", sref_req, 1);
        repeat (4) @(negedge clk);
        chk(mode == 2'b00 && !sref_req, "R8 released", sref_req, 0);

        // Second cycle with autostop off and a different wake line
        sdclk_autostop = 1'b0; wake_en = 8'h80;
        tick(); suspend_req = 1'b1; tick(); suspend_req = 1'b0;
        wait_mode(2'b10);
        chk(sdram_clk_en, "R9 autostop off", sdram_clk_en, 1);
        tick(); wake_evt = 8'h80; tick(); wake_evt = 8'h00;
        wait_mode(2'b00);
        repeat (4) @(negedge clk);
        chk(mode == 2'b00 && !sref_req && clk_sel, "R8 second resume", mode, 0);

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule